// File: doc/BRIEF.md
# Mailbox Ring Scan Engine

This block is the device side of a host/adapter mailbox exchange. A host shares one memory region with the engine. The region holds a ring of N outgoing slots, followed at once by a ring of N incoming slots. The engine reaches that region through a single word-wide memory port. Each transfer on the port is a request held until it is acknowledged, and it can carry byte enables.

After a kick, the engine walks the outgoing ring from where it last stopped. For each slot that asks for a start or an abort, it frees the slot and then acts on it. A start hands the request pointer to a downstream queue and records the pointer as outstanding. An abort for an outstanding pointer is forwarded with an abort flag. An abort for an unknown pointer is answered directly with a "not found" completion.

Completions from downstream arrive on a test port. Each one, like any answer the engine creates itself, is written into the next incoming slot and then flagged by an interrupt. If that slot is still owned by the host, the engine waits. The ring base, the slot count and one of two entry layouts (a narrow layout with 24-bit pointers, or a wide layout with 32-bit pointers) are loaded at set-up.

Top module: `mbx_ring_engine`

## Requirements
- R1: After reset, `irqFlags` is 0x00, `memReq` and `reqValid` are low and `cmpReady` is high.
- R2: Narrow layout, one 32-bit word per slot: byte 0 holds the code and bytes 1..3 hold the pointer, most significant byte in byte 1. A slot with code 0x01 (start) or 0x02 (abort) is released by writing 0x00 to its code byte alone, with the pointer bytes left intact. This release happens before `reqValid` pulses with the pointer.
- R3: Wide layout, two words per slot: word 0 holds the 32-bit pointer, least significant byte in byte 0. Word 1 holds the adapter status in byte 0, the device status in byte 1, a zero pad in byte 2 and the code in byte 3.
- R4: A scan starts at the slot after the last one consumed and wraps after N slots. It stops at the first slot whose code is neither 0x01 nor 0x02, and forwards pointers in ring order.
- R5: Incoming slots start N slots past the ring base. Each completion fills the next incoming slot with its pointer, statuses and code (0x01 ok, 0x02 aborted, 0x03 not found, 0x04 error), and the index wraps after N.
- R6: In an incoming slot, every pointer and status byte is written before the code byte.
- R7: While the next incoming slot holds a non-zero code, the engine leaves it unchanged and keeps re-reading it. It fills the slot once the host has written the code to zero.
- R8: Each completion sets `irqFlags` to 0x81 (bit 0 = incoming slot loaded, bit 7 = flags valid). `irqClear` returns it to 0x00.
- R9: An abort naming an outstanding pointer emits `reqValid` with `reqAbort` high and writes no completion.
- R10: An abort naming a pointer that is not outstanding produces completion code 0x03 carrying that pointer, with both statuses at 0x00.
- R11: `cmpReady` is high only while the engine is idle. An injected completion is taken when `cmpValid` and `cmpReady` are both high.
- R12: A memory request keeps its address, write enable, byte enables and write data steady until `memAck`.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Loads the ring set-up and zeroes both indices |
| cfgBase | input | AW | Word address of outgoing slot 0 |
| cfgCount | input | CNT_W | Slots per ring (N) |
| cfgWide | input | 1 | 1 selects the wide layout |
| startKick | input | 1 | Asks for an outgoing scan |
| cmpValid | input | 1 | An injected completion is offered |
| cmpReady | output | 1 | Engine accepts an injected completion |
| cmpPtr | input | 32 | Request pointer being completed |
| cmpCode | input | 8 | Completion code |
| cmpAdStat | input | 8 | Adapter status (wide layout only) |
| cmpDevStat | input | 8 | Device status (wide layout only) |
| reqValid | output | 1 | One-cycle handoff of a consumed request |
| reqPtr | output | 32 | Pointer of the handed-off request |
| reqAbort | output | 1 | The handoff is an abort of an outstanding request |
| irqFlags | output | 8 | Interrupt flags |
| irqClear | input | 1 | Clears the interrupt flags |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memBe | output | 4 | Byte enables for writes |
| memAddr | output | AW | Word address |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request done; read data valid |
| memRdata | input | 32 | Read data |

## Verification
The bench goes after the places where the two rings can drift apart. These are a scan that wraps past slot N-1, an incoming index that wraps while the host has not yet freed an old slot, and an incoming slot still owned by the host. A design that resumed from slot 0 would forward requests twice or out of order. One that ignored ownership would overwrite an unread completion and raise a second interrupt.

A memory model watches the byte lanes. It flags any code byte that lands before its pointer and status bytes, which is how a host could read a stale pointer. The abort cases separate a pointer that is outstanding from one that is not: an engine that mixed them up would either answer a live request with "not found" or forward a useless abort.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] CODE_FREE   = 8'h00;
  localparam logic [7:0] CODE_START  = 8'h01;
  localparam logic [7:0] CODE_ABORT  = 8'h02;
  localparam logic [7:0] CODE_NOTFND = 8'h03;
  localparam logic [7:0] IRQ_LOADED  = 8'h81;

  typedef enum logic [2:0] {
    OP_NONE, OP_RD_OCODE, OP_RD_OPTR, OP_FREE,
    OP_RD_IN, OP_WR_PTR, OP_WR_STAT, OP_WR_CODE
  } memOp_t;

  typedef struct packed {
    memOp_t op;
    logic   advOut;
    logic   advIn;
    logic   tblAdd;
    logic   loadExt;
    logic   loadMiss;
    logic   emitReq;
    logic   emitAbort;
    logic   setIrq;
  } strobe_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wide,
  input  logic       startKick,
  input  logic       cmpValid,
  input  logic       memAck,
  input  logic [7:0] rdCode,
  input  logic [7:0] outCode,
  input  logic       tblHit,
  output strobe_t    stb,
  output logic       cmpReady
);
  typedef enum logic [3:0] {
    S_IDLE, S_RD_OCODE, S_RD_OPTR, S_FREE, S_DISPATCH,
    S_CHK_IN, S_WR_PTR, S_WR_STAT, S_WR_CODE
  } state_t;

  state_t state, stateNext;
  logic   startPend;
  logic   fromScan;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      startPend <= 1'b0;
      fromScan  <= 1'b0;
    end else begin
      state <= stateNext;
      if (startKick)
        startPend <= 1'b1;
      else if (state == S_IDLE && stateNext == S_RD_OCODE)
        startPend <= 1'b0;
      if (state == S_DISPATCH)
        fromScan <= 1'b1;
      else if (state == S_IDLE)
        fromScan <= 1'b0;
    end
  end

  always_comb begin
    stb       = '0;
    stb.op    = OP_NONE;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (cmpValid) begin
          stb.loadExt = 1'b1;
          stateNext   = S_CHK_IN;
        end else if (startPend) begin
          stateNext = S_RD_OCODE;
        end
      end
      S_RD_OCODE: begin
        stb.op = OP_RD_OCODE;
        if (memAck) begin
          if (rdCode == CODE_START || rdCode == CODE_ABORT)
            stateNext = wide ? S_RD_OPTR : S_FREE;
          else
            stateNext = S_IDLE;
        end
      end
      S_RD_OPTR: begin
        stb.op = OP_RD_OPTR;
        if (memAck) stateNext = S_FREE;
      end
      S_FREE: begin
        stb.op = OP_FREE;
        if (memAck) stateNext = S_DISPATCH;
      end
      S_DISPATCH: begin
        stb.advOut = 1'b1;
        if (outCode == CODE_START) begin
          stb.tblAdd  = 1'b1;
          stb.emitReq = 1'b1;
          stateNext   = S_RD_OCODE;
        end else if (tblHit) begin
          stb.emitReq   = 1'b1;
          stb.emitAbort = 1'b1;
          stateNext     = S_RD_OCODE;
        end else begin
          stb.loadMiss = 1'b1;
          stateNext    = S_CHK_IN;
        end
      end
      S_CHK_IN: begin
        stb.op = OP_RD_IN;
        if (memAck && rdCode == CODE_FREE) stateNext = S_WR_PTR;
      end
      S_WR_PTR: begin
        stb.op = OP_WR_PTR;
        if (memAck) stateNext = wide ? S_WR_STAT : S_WR_CODE;
      end
      S_WR_STAT: begin
        stb.op = OP_WR_STAT;
        if (memAck) stateNext = S_WR_CODE;
      end
      S_WR_CODE: begin
        stb.op = OP_WR_CODE;
        if (memAck) begin
          stb.setIrq = 1'b1;
          stb.advIn  = 1'b1;
          stateNext  = fromScan ? S_RD_OCODE : S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign cmpReady = (state == S_IDLE);
endmodule

// File: rtl/mbx_dp.sv
module mbx_dp
  import mbx_pkg::*;
#(
  parameter int AW        = 12,
  parameter int MAX_SLOTS = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 cfgLoad,
  input  logic [AW-1:0]                        cfgBase,
  input  logic [$clog2(MAX_SLOTS+1)-1:0]       cfgCount,
  input  logic                                 cfgWide,
  input  strobe_t                              stb,
  input  logic [31:0]                          cmpPtr,
  input  logic [7:0]                           cmpCode,
  input  logic [7:0]                           cmpAdStat,
  input  logic [7:0]                           cmpDevStat,
  input  logic                                 memAck,
  input  logic [31:0]                          memRdata,
  input  logic                                 irqClear,
  output logic                                 wide,
  output logic [7:0]                           rdCode,
  output logic [7:0]                           outCode,
  output logic                                 tblHit,
  output logic [AW-1:0]                        memAddr,
  output logic                                 memWe,
  output logic [3:0]                           memBe,
  output logic [31:0]                          memWdata,
  output logic                                 reqValid,
  output logic [31:0]                          reqPtr,
  output logic                                 reqAbort,
  output logic [7:0]                           irqFlags
);
  localparam int CNT_W = $clog2(MAX_SLOTS + 1);
  localparam int IDX_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;
  localparam int TBL   = (MAX_SLOTS > 2) ? MAX_SLOTS - 1 : 1;
  localparam int TBL_W = (TBL > 1) ? $clog2(TBL) : 1;

  logic [AW-1:0]    base;
  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] oIdx, iIdx;
  logic [31:0]      curPtr, cPtr;
  logic [7:0]       cCode, cAd, cDev;
  logic [TBL-1:0]   tblValid, hitCur, hitExt;
  logic [31:0]      tblPtr [TBL];
  logic [TBL_W-1:0] freeSel;
  logic             anyFree;
  logic [CNT_W-1:0] oNext, iNext;
  logic [AW-1:0]    oSlot, iSlot, wOff;
  logic [3:0]       codeLane;

  genvar g;
  generate
    for (g = 0; g < TBL; g++) begin : g_match
      assign hitCur[g] = tblValid[g] && (tblPtr[g] == curPtr);
      assign hitExt[g] = tblValid[g] && (tblPtr[g] == cmpPtr);
    end
  endgenerate
  assign tblHit = |hitCur;

  always_comb begin
    freeSel = '0;
    anyFree = 1'b0;
    for (int i = TBL - 1; i >= 0; i--) begin
      if (!tblValid[i]) begin
        freeSel = TBL_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  assign rdCode   = wide ? memRdata[31:24] : memRdata[7:0];
  assign codeLane = wide ? 4'b1000 : 4'b0001;
  assign wOff     = wide ? AW'(1) : AW'(0);
  assign oSlot    = base + (wide ? AW'({oIdx, 1'b0}) : AW'(oIdx));
  assign iSlot    = base + (wide ? AW'({count, 1'b0}) : AW'(count))
                         + (wide ? AW'({iIdx, 1'b0}) : AW'(iIdx));
  assign oNext    = CNT_W'(oIdx) + CNT_W'(1);
  assign iNext    = CNT_W'(iIdx) + CNT_W'(1);

  always_comb begin
    memAddr  = oSlot + wOff;
    memWe    = 1'b0;
    memBe    = 4'b0000;
    memWdata = 32'h0;
    case (stb.op)
      OP_RD_OPTR: memAddr = oSlot;
      OP_FREE: begin
        memWe = 1'b1;
        memBe = codeLane;
      end
      OP_RD_IN: memAddr = iSlot + wOff;
      OP_WR_PTR: begin
        memAddr  = iSlot;
        memWe    = 1'b1;
        memBe    = wide ? 4'b1111 : 4'b1110;
        memWdata = wide ? cPtr : {cPtr[7:0], cPtr[15:8], cPtr[23:16], 8'h00};
      end
      OP_WR_STAT: begin
        memAddr  = iSlot + wOff;
        memWe    = 1'b1;
        memBe    = 4'b0111;
        memWdata = {8'h00, 8'h00, cDev, cAd};
      end
      OP_WR_CODE: begin
        memAddr  = iSlot + wOff;
        memWe    = 1'b1;
        memBe    = codeLane;
        memWdata = wide ? {cCode, 24'h0} : {24'h0, cCode};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base     <= '0;
      count    <= CNT_W'(MAX_SLOTS);
      wide     <= 1'b0;
      oIdx     <= '0;
      iIdx     <= '0;
      curPtr   <= '0;
      outCode  <= '0;
      cPtr     <= '0;
      cCode    <= '0;
      cAd      <= '0;
      cDev     <= '0;
      tblValid <= '0;
      reqValid <= 1'b0;
      reqPtr   <= '0;
      reqAbort <= 1'b0;
      irqFlags <= '0;
      for (int i = 0; i < TBL; i++) tblPtr[i] <= '0;
    end else begin
      if (cfgLoad) begin
        base  <= cfgBase;
        count <= cfgCount;
        wide  <= cfgWide;
        oIdx  <= '0;
        iIdx  <= '0;
      end else begin
        if (stb.advOut) oIdx <= (oNext == count) ? '0 : oNext[IDX_W-1:0];
        if (stb.advIn)  iIdx <= (iNext == count) ? '0 : iNext[IDX_W-1:0];
      end
      if (memAck && stb.op == OP_RD_OCODE) begin
        outCode <= rdCode;
        if (!wide) curPtr <= {8'h00, memRdata[15:8], memRdata[23:16], memRdata[31:24]};
      end
      if (memAck && stb.op == OP_RD_OPTR) curPtr <= memRdata;
      if (stb.loadExt) begin
        cPtr  <= cmpPtr;
        cCode <= cmpCode;
        cAd   <= cmpAdStat;
        cDev  <= cmpDevStat;
      end else if (stb.loadMiss) begin
        cPtr  <= curPtr;
        cCode <= CODE_NOTFND;
        cAd   <= 8'h00;
        cDev  <= 8'h00;
      end
      for (int i = 0; i < TBL; i++) begin
        if (stb.loadExt && hitExt[i]) tblValid[i] <= 1'b0;
        if (stb.tblAdd && anyFree && freeSel == TBL_W'(i)) begin
          tblValid[i] <= 1'b1;
          tblPtr[i]   <= curPtr;
        end
      end
      reqValid <= stb.emitReq;
      if (stb.emitReq) begin
        reqPtr   <= curPtr;
        reqAbort <= stb.emitAbort;
      end
      if (stb.setIrq)   irqFlags <= IRQ_LOADED;
      else if (irqClear) irqFlags <= 8'h00;
    end
  end
endmodule

// File: rtl/mbx_ring_engine.sv
module mbx_ring_engine
  import mbx_pkg::*;
#(
  parameter int AW        = 12,
  parameter int MAX_SLOTS = 8,
  localparam int CNT_W    = $clog2(MAX_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [AW-1:0]    cfgBase,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             cfgWide,
  input  logic             startKick,
  input  logic             cmpValid,
  output logic             cmpReady,
  input  logic [31:0]      cmpPtr,
  input  logic [7:0]       cmpCode,
  input  logic [7:0]       cmpAdStat,
  input  logic [7:0]       cmpDevStat,
  output logic             reqValid,
  output logic [31:0]      reqPtr,
  output logic             reqAbort,
  output logic [7:0]       irqFlags,
  input  logic             irqClear,
  output logic             memReq,
  output logic             memWe,
  output logic [3:0]       memBe,
  output logic [AW-1:0]    memAddr,
  output logic [31:0]      memWdata,
  input  logic             memAck,
  input  logic [31:0]      memRdata
);
  strobe_t    stb;
  logic       wide, tblHit;
  logic [7:0] rdCode, outCode;

  assign memReq = (stb.op != OP_NONE);

  mbx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wide(wide), .startKick(startKick),
    .cmpValid(cmpValid), .memAck(memAck), .rdCode(rdCode),
    .outCode(outCode), .tblHit(tblHit), .stb(stb), .cmpReady(cmpReady)
  );

  mbx_dp #(.AW(AW), .MAX_SLOTS(MAX_SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgBase(cfgBase),
    .cfgCount(cfgCount), .cfgWide(cfgWide), .stb(stb),
    .cmpPtr(cmpPtr), .cmpCode(cmpCode), .cmpAdStat(cmpAdStat),
    .cmpDevStat(cmpDevStat), .memAck(memAck), .memRdata(memRdata),
    .irqClear(irqClear), .wide(wide), .rdCode(rdCode), .outCode(outCode),
    .tblHit(tblHit), .memAddr(memAddr), .memWe(memWe), .memBe(memBe),
    .memWdata(memWdata), .reqValid(reqValid), .reqPtr(reqPtr),
    .reqAbort(reqAbort), .irqFlags(irqFlags)
  );
endmodule

// File: rtl/mbx_ring_engine_chk.sv
module mbx_ring_engine_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          memReq,
  input logic          memAck,
  input logic          memWe,
  input logic [3:0]    memBe,
  input logic [AW-1:0] memAddr,
  input logic [31:0]   memWdata,
  input logic [7:0]    irqFlags,
  input logic          irqClear,
  input logic          reqValid,
  input logic          cmpReady
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe)
                          && $stable(memBe) && $stable(memWdata)); // R12

  AST_IRQ_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    irqFlags == 8'h00 || irqFlags == 8'h81); // R8

  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlags[0]) |-> $past(memReq && memAck && memWe)); // R8

  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rstN)
    irqClear && !(memReq && memAck && memWe) |=> irqFlags == 8'h00); // R8

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cmpReady |-> !memReq); // R11

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $past(memWe && memAck, 2)); // R2

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid); // R4
endmodule

bind mbx_ring_engine mbx_ring_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck), .memWe(memWe),
  .memBe(memBe), .memAddr(memAddr), .memWdata(memWdata), .irqFlags(irqFlags),
  .irqClear(irqClear), .reqValid(reqValid), .cmpReady(cmpReady)
);

// File: tb/mbx_ring_engine_tb.sv
module mbx_ring_engine_tb;
  localparam int AW = 12;
  localparam int MS = 8;
  localparam int CW = $clog2(MS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0, cfgWide = 1'b0, startKick = 1'b0;
  logic [AW-1:0] cfgBase = '0;
  logic [CW-1:0] cfgCount = '0;
  logic cmpValid = 1'b0, irqClear = 1'b0;
  logic [31:0] cmpPtr = '0;
  logic [7:0] cmpCode = '0, cmpAdStat = '0, cmpDevStat = '0;
  logic cmpReady, reqValid, reqAbort, memReq, memWe;
  logic [31:0] reqPtr, memWdata;
  logic [7:0] irqFlags;
  logic [3:0] memBe;
  logic [AW-1:0] memAddr;
  logic memAck = 1'b0;
  logic [31:0] memRdata = '0;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  mbx_ring_engine #(.AW(AW), .MAX_SLOTS(MS)) u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgBase(cfgBase),
    .cfgCount(cfgCount), .cfgWide(cfgWide), .startKick(startKick),
    .cmpValid(cmpValid), .cmpReady(cmpReady), .cmpPtr(cmpPtr),
    .cmpCode(cmpCode), .cmpAdStat(cmpAdStat), .cmpDevStat(cmpDevStat),
    .reqValid(reqValid), .reqPtr(reqPtr), .reqAbort(reqAbort),
    .irqFlags(irqFlags), .irqClear(irqClear), .memReq(memReq), .memWe(memWe),
    .memBe(memBe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata)
  );

  // shared memory model with lane-order tracking for incoming slots
  logic [31:0] mem [0:63];
  logic        fieldSeen [0:63];
  int inLo = 0, inHi = 0, orderBad = 0;
  logic benchWide = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
    end else if (memReq && !memAck) begin
      int a;
      a = int'(memAddr[5:0]);
      memAck   <= 1'b1;
      memRdata <= mem[a];
      if (memWe) begin
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[a][8*b +: 8] <= memWdata[8*b +: 8];
        if (a >= inLo && a < inHi) begin
          if ((memBe & (benchWide ? 4'b0111 : 4'b1110)) != 4'b0000 || memBe == 4'b1111)
            fieldSeen[a] = 1'b1;
          if (benchWide ? (memBe[3] && memWdata[31:24] != 8'h00 && memBe != 4'b1111)
                        : (memBe[0] && memWdata[7:0] != 8'h00)) begin
            if (benchWide ? !(fieldSeen[a-1] && fieldSeen[a]) : !fieldSeen[a])
              orderBad++;
            fieldSeen[a] = 1'b0;
            if (benchWide) fieldSeen[a-1] = 1'b0;
          end
        end
      end
    end else begin
      memAck <= 1'b0;
    end
  end

  logic [31:0] reqLogPtr [0:31];
  logic        reqLogAb  [0:31];
  int reqCnt = 0;
  always @(posedge clk) begin
    if (rstN && reqValid && reqCnt < 32) begin
      reqLogPtr[reqCnt] = reqPtr;
      reqLogAb[reqCnt]  = reqAbort;
      reqCnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] narrow(input logic [31:0] p, input logic [7:0] c);
    return {p[7:0], p[15:8], p[23:16], c};
  endfunction

  task automatic waitIdle();
    int quiet = 0;
    for (int n = 0; n < 2000 && quiet < 6; n++) begin
      @(negedge clk);
      if (cmpReady && !memReq) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic kick();
    @(negedge clk) startKick = 1'b1;
    @(negedge clk) startKick = 1'b0;
    waitIdle();
  endtask

  task automatic setup(input int b, input int n, input logic w);
    @(negedge clk);
    cfgBase = AW'(b); cfgCount = CW'(n); cfgWide = w; cfgLoad = 1'b1;
    benchWide = w;
    inLo = w ? b + 2 * n : b + n;
    inHi = w ? b + 4 * n : b + 2 * n;
    @(negedge clk) cfgLoad = 1'b0;
  endtask

  task automatic inject(input logic [31:0] p, input logic [7:0] c,
                        input logic [7:0] ad, input logic [7:0] dv);
    @(negedge clk);
    while (!cmpReady) @(negedge clk);
    cmpValid = 1'b1; cmpPtr = p; cmpCode = c; cmpAdStat = ad; cmpDevStat = dv;
    @(negedge clk) cmpValid = 1'b0;
  endtask

  task automatic clearIrq();
    @(negedge clk) irqClear = 1'b1;
    @(negedge clk) irqClear = 1'b0;
    chk("R8 clear", {24'h0, irqFlags}, 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 irq", {24'h0, irqFlags}, 32'h0);
    chk("R1 memReq", {31'h0, memReq}, 32'h0);
    chk("R1 reqValid", {31'h0, reqValid}, 32'h0);
    chk("R1 cmpReady", {31'h0, cmpReady}, 32'h1);
  endtask

  task automatic t_start24();
    int c0;
    setup(8, 4, 1'b0);
    mem[8]  = narrow(32'h123456, 8'h01);
    mem[9]  = narrow(32'hABCDEF, 8'h01);
    mem[10] = 32'h33221100;
    c0 = reqCnt;
    kick();
    chk("R2 count", 32'(reqCnt - c0), 32'd2);
    chk("R2 ptr0", reqLogPtr[c0], 32'h123456);
    chk("R2 ptr1", reqLogPtr[c0 + 1], 32'hABCDEF);
    chk("R2 abortflag", {31'h0, reqLogAb[c0]}, 32'h0);
    chk("R2 freed slot", mem[8], narrow(32'h123456, 8'h00));
    chk("R4 stop slot untouched", mem[10], 32'h33221100);
    chk("R8 no irq on handoff", {24'h0, irqFlags}, 32'h0);
  endtask

  task automatic t_wrap();
    int c0;
    mem[10] = narrow(32'h000111, 8'h01);
    mem[11] = narrow(32'h000222, 8'h01);
    mem[8]  = narrow(32'h000333, 8'h01);
    mem[9]  = 32'h0;
    c0 = reqCnt;
    kick();
    chk("R4 count", 32'(reqCnt - c0), 32'd3);
    chk("R4 order a", reqLogPtr[c0], 32'h000111);
    chk("R4 order b", reqLogPtr[c0 + 1], 32'h000222);
    chk("R4 wrapped", reqLogPtr[c0 + 2], 32'h000333);
  endtask

  task automatic t_complete24();
    for (int i = 12; i < 16; i++) mem[i] = 32'h0;
    inject(32'h123456, 8'h01, 8'h00, 8'h00);
    waitIdle();
    chk("R5 slot0", mem[12], narrow(32'h123456, 8'h01));
    chk("R8 set", {24'h0, irqFlags}, 32'h81);
    clearIrq();
    inject(32'hABCDEF, 8'h04, 8'h00, 8'h00);
    waitIdle();
    chk("R5 slot1", mem[13], narrow(32'hABCDEF, 8'h04));
    clearIrq();
  endtask

  task automatic t_stall();
    mem[14] = 32'h000000AA;
    inject(32'h000111, 8'h01, 8'h00, 8'h00);
    repeat (40) @(negedge clk);
    chk("R7 held slot", mem[14], 32'h000000AA);
    chk("R7 no irq", {24'h0, irqFlags}, 32'h0);
    chk("R11 busy", {31'h0, cmpReady}, 32'h0);
    mem[14] = 32'h0;
    waitIdle();
    chk("R7 filled", mem[14], narrow(32'h000111, 8'h01));
    chk("R8 after stall", {24'h0, irqFlags}, 32'h81);
    clearIrq();
  endtask

  task automatic t_abort();
    int c0;
    mem[9]  = narrow(32'h000222, 8'h02);
    mem[10] = narrow(32'h0F0E0D, 8'h02);
    mem[11] = 32'h0;
    mem[15] = 32'h0;
    c0 = reqCnt;
    kick();
    chk("R9 one handoff", 32'(reqCnt - c0), 32'd1);
    chk("R9 ptr", reqLogPtr[c0], 32'h000222);
    chk("R9 abort flag", {31'h0, reqLogAb[c0]}, 32'h1);
    chk("R10 notfound", mem[15], narrow(32'h0F0E0D, 8'h03));
    chk("R10 irq", {24'h0, irqFlags}, 32'h81);
    clearIrq();
    mem[12] = 32'h0;
    inject(32'h000222, 8'h02, 8'h00, 8'h00);
    waitIdle();
    chk("R5 in wrap", mem[12], narrow(32'h000222, 8'h02));
    clearIrq();
  endtask

  task automatic t_wide();
    int c0;
    setup(16, 4, 1'b1);
    for (int i = 16; i < 32; i++) mem[i] = 32'h0;
    mem[16] = 32'h89ABCDEF;
    mem[17] = 32'h01000000;
    c0 = reqCnt;
    kick();
    chk("R3 count", 32'(reqCnt - c0), 32'd1);
    chk("R3 ptr", reqLogPtr[c0], 32'h89ABCDEF);
    chk("R3 freed code", mem[17], 32'h0);
    chk("R3 ptr kept", mem[16], 32'h89ABCDEF);
    inject(32'h89ABCDEF, 8'h04, 8'h11, 8'h02);
    waitIdle();
    chk("R3 in ptr", mem[24], 32'h89ABCDEF);
    chk("R3 in status", mem[25], 32'h04000211);
    chk("R8 wide irq", {24'h0, irqFlags}, 32'h81);
    clearIrq();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'h0;
      fieldSeen[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_start24();
    t_wrap();
    t_complete24();
    t_stall();
    t_abort();
    t_wide();
    chk("R6 lane order", 32'(orderBad), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule